// File: doc/BRIEF.md
# Trace Line Packer

This block assembles trace lines for a decoded micro-op cache while that cache is being refilled after a miss. A pulse on `missIn` puts it into build mode. In build mode it accepts at most one decoded source instruction per cycle. Each instruction carries one to four micro-ops, its fetch address, a branch flag with a predicted direction, and a flag that marks it as long.

Micro-ops are packed into six-slot lines in the order they arrive. A branch does not end a line. The micro-ops that follow it on the predicted path go into the next free slots, and the predicted direction is recorded against the branch's last slot. A long instruction is not expanded. It takes exactly one slot, which holds a marker bit and its microcode entry point.

An instruction is never split across two lines. Finished lines leave through a single registered write port. A one-cycle `fillDone` pulse closes the segment. It fires when the configured line budget has been used up or when `segEnd` is raised.

Top module: `tseg_builder`

## Requirements
- R1: While not building, `instValid` and `segEnd` are ignored: no write occurs and `fillDone` stays low. Build mode starts on the clock edge that samples `missIn` high.
- R2: Micro-ops of regular instructions occupy consecutive slots in arrival order. Within an instruction, micro-op k comes from bits [k*15 +: 15] of `instUops`. Each slot is 16 bits and is stored as {1'b0, micro-op}. Slot s is at `wrSlots[s*16 +: 16]`.
- R3: A branch instruction does not close the line, and later instructions continue in the following slots. The `wrTaken` bit of the branch's last slot carries `predTaken`. All other `wrTaken` bits are 0.
- R4: An instruction with `instLong` set occupies exactly one slot, encoded as {1'b1, instEntry}, whatever the value of `instCount`.
- R5: If an instruction does not fit in the free slots, the current line is written unchanged. The instruction then starts a new line at slot 0, and that new line's tag is the instruction's address.
- R6: When an instruction brings the line to exactly six slots, that line is written, including the instruction, and the next instruction starts an empty line.
- R7: Each written line has `wrTag` equal to the address of its first instruction. `wrValid` is a contiguous mask from bit 0, with one bit per occupied slot.
- R8: The write that makes the segment's line count reach `MAX_LINES` (default 2) comes with `fillDone`, and the block returns to idle. If that write was caused by an instruction that did not fit, the instruction is dropped.
- R9: `segEnd` in build mode writes the partial line (no write if the line is empty), pulses `fillDone`, and returns to idle. An instruction presented in the same cycle is ignored.
- R10: During reset `wrEn` and `fillDone` are 0, and the block leaves reset idle with an empty line.
- R11: Outputs are registered. A write and its `fillDone` appear in the cycle after the edge that sampled the causing input, and there is at most one line write per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missIn | input | 1 | Trace cache miss; starts build mode when idle |
| instValid | input | 1 | A decoded instruction is presented |
| instAddr | input | 16 | Fetch address of the instruction |
| instCount | input | 3 | Number of micro-ops, 1 to 4 |
| instUops | input | 60 | Up to four 15-bit micro-ops, micro-op k at bits [k*15 +: 15] |
| instLong | input | 1 | Instruction is microcoded; store a tag slot |
| instEntry | input | 15 | Microcode entry point for a long instruction |
| instBranch | input | 1 | Instruction ends in a branch |
| predTaken | input | 1 | Predicted direction of that branch |
| segEnd | input | 1 | Close the segment now |
| wrEn | output | 1 | Line write strobe |
| wrTag | output | 16 | Address of the line's first instruction |
| wrValid | output | 6 | Occupied-slot mask |
| wrSlots | output | 96 | Six 16-bit slots, slot s at bits [s*16 +: 16] |
| wrTaken | output | 6 | Predicted direction per slot at branch ends |
| fillDone | output | 1 | One-cycle segment-complete pulse |

## Verification
The properties assume that `instCount` lies between 1 and 4 whenever a regular instruction is valid. They also assume that `missIn` and the instruction inputs change only between clock edges. Under those assumptions every write and every completion pulse can be traced back to an input sampled one cycle earlier.

The stimulus keeps within these assumptions. All inputs are driven on the falling edge, and every row of the vector table and every directed case uses counts in the legal range. A long instruction's count is left at a nonzero value that the block must disregard.

The sequences sweep lines that overflow, lines that fill exactly, the end of the line budget, early termination with and without a partial line, and input arriving while the block is idle.

// File: rtl/tseg_pkg.sv
package tseg_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_BUILD
  } tsegState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearLine;  // empty the working line
    logic place;      // load the merged line into the working line
    logic base;       // merge starts from an empty line at slot 0
    logic wrCur;      // write the working line as it stands
    logic wrMerged;   // write the line with the incoming instruction added
  } tsegCtl_t;

endpackage

// File: rtl/tseg_ctrl.sv
module tseg_ctrl
  import tseg_pkg::*;
#(
  parameter int SLOTS     = 6,
  parameter int MAX_UOPS  = 4,
  parameter int MAX_LINES = 2,
  localparam int FILL_W   = $clog2(SLOTS + 1),
  localparam int CNT_W    = $clog2(MAX_UOPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missIn,
  input  logic              instValid,
  input  logic [CNT_W-1:0]  instCount,
  input  logic              instLong,
  input  logic              segEnd,
  input  logic [FILL_W-1:0] fill,
  output tsegCtl_t          ctl,
  output logic              fillDone
);

  localparam int LC_W  = $clog2(MAX_LINES + 1);
  localparam int SUM_W = FILL_W + 1;

  tsegState_t       state, nxtState;
  logic [LC_W-1:0]  lines, nxtLines;
  logic [FILL_W-1:0] need;
  logic [SUM_W-1:0] sum;
  logic             lastLine;
  logic             doneNow;

  assign need     = instLong ? FILL_W'(1) : FILL_W'(instCount);
  assign sum      = SUM_W'(fill) + SUM_W'(need);
  assign lastLine = (lines == LC_W'(MAX_LINES - 1));

  always_comb begin
    ctl      = '0;
    nxtState = state;
    nxtLines = lines;
    doneNow  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (missIn) begin
          ctl.clearLine = 1'b1;
          nxtState      = ST_BUILD;
          nxtLines      = '0;
        end
      end
      ST_BUILD: begin
        if (segEnd) begin
          ctl.wrCur     = (fill != '0);
          ctl.clearLine = 1'b1;
          doneNow       = 1'b1;
          nxtState      = ST_IDLE;
        end else if (instValid) begin
          if (sum > SUM_W'(SLOTS)) begin
            ctl.wrCur = 1'b1;
            nxtLines  = lines + 1'b1;
            if (lastLine) begin
              ctl.clearLine = 1'b1;
              doneNow       = 1'b1;
              nxtState      = ST_IDLE;
            end else begin
              ctl.place = 1'b1;
              ctl.base  = 1'b1;
            end
          end else if (sum == SUM_W'(SLOTS)) begin
            ctl.wrMerged = 1'b1;
            ctl.place    = 1'b1;
            nxtLines     = lines + 1'b1;
            if (lastLine) begin
              doneNow  = 1'b1;
              nxtState = ST_IDLE;
            end
          end else begin
            ctl.place = 1'b1;
          end
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lines    <= '0;
      fillDone <= 1'b0;
    end else begin
      state    <= nxtState;
      lines    <= nxtLines;
      fillDone <= doneNow;
    end
  end

endmodule

// File: rtl/tseg_dpath.sv
module tseg_dpath
  import tseg_pkg::*;
#(
  parameter int SLOTS    = 6,
  parameter int UOP_W    = 16,
  parameter int MAX_UOPS = 4,
  parameter int ADDR_W   = 16,
  localparam int OP_W    = UOP_W - 1,
  localparam int FILL_W  = $clog2(SLOTS + 1),
  localparam int CNT_W   = $clog2(MAX_UOPS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tsegCtl_t                  ctl,
  input  logic [ADDR_W-1:0]         instAddr,
  input  logic [CNT_W-1:0]          instCount,
  input  logic [MAX_UOPS*OP_W-1:0]  instUops,
  input  logic                      instLong,
  input  logic [OP_W-1:0]           instEntry,
  input  logic                      instBranch,
  input  logic                      predTaken,
  output logic [FILL_W-1:0]         fill,
  output logic                      wrEn,
  output logic [ADDR_W-1:0]         wrTag,
  output logic [SLOTS-1:0]          wrValid,
  output logic [SLOTS*UOP_W-1:0]    wrSlots,
  output logic [SLOTS-1:0]          wrTaken
);

  localparam int SLOT_IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0][UOP_W-1:0] lineSlots, mrgSlots;
  logic [SLOTS-1:0]            lineTaken, mrgTaken;
  logic [ADDR_W-1:0]           lineTag, mrgTag;
  logic [FILL_W-1:0]           lineFill, mrgFill, pos, need;
  int                          lastIdx;

  function automatic logic [SLOTS-1:0] fillMask(input logic [FILL_W-1:0] f);
    logic [SLOTS-1:0] m;
    for (int s = 0; s < SLOTS; s++) m[s] = (s < int'(f));
    return m;
  endfunction

  assign fill = lineFill;

  // Line with the incoming instruction appended
  always_comb begin
    need     = instLong ? FILL_W'(1) : FILL_W'(instCount);
    pos      = ctl.base ? '0 : lineFill;
    mrgSlots = ctl.base ? '0 : lineSlots;
    mrgTaken = ctl.base ? '0 : lineTaken;
    mrgTag   = (pos == '0) ? instAddr : lineTag;
    mrgFill  = pos + need;
    for (int k = 0; k < MAX_UOPS; k++) begin
      if (k < int'(need) && (int'(pos) + k) < SLOTS) begin
        if (instLong) mrgSlots[SLOT_IW'(int'(pos) + k)] = {1'b1, instEntry};
        else          mrgSlots[SLOT_IW'(int'(pos) + k)] = {1'b0, instUops[k*OP_W +: OP_W]};
      end
    end
    lastIdx = int'(pos) + int'(need) - 1;
    if (instBranch && lastIdx >= 0 && lastIdx < SLOTS)
      mrgTaken[SLOT_IW'(lastIdx)] = predTaken;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSlots <= '0;
      lineTaken <= '0;
      lineTag   <= '0;
      lineFill  <= '0;
      wrEn      <= 1'b0;
      wrTag     <= '0;
      wrValid   <= '0;
      wrSlots   <= '0;
      wrTaken   <= '0;
    end else begin
      wrEn <= ctl.wrCur | ctl.wrMerged;
      if (ctl.wrMerged) begin
        wrTag   <= mrgTag;
        wrValid <= fillMask(mrgFill);
        wrSlots <= mrgSlots;
        wrTaken <= mrgTaken;
      end else if (ctl.wrCur) begin
        wrTag   <= lineTag;
        wrValid <= fillMask(lineFill);
        wrSlots <= lineSlots;
        wrTaken <= lineTaken;
      end
      if (ctl.wrMerged || (ctl.clearLine && !ctl.place)) begin
        lineSlots <= '0;
        lineTaken <= '0;
        lineTag   <= '0;
        lineFill  <= '0;
      end else if (ctl.place) begin
        lineSlots <= mrgSlots;
        lineTaken <= mrgTaken;
        lineTag   <= mrgTag;
        lineFill  <= mrgFill;
      end
    end
  end

endmodule

// File: rtl/tseg_builder.sv
module tseg_builder
  import tseg_pkg::*;
#(
  parameter int SLOTS     = 6,
  parameter int UOP_W     = 16,
  parameter int MAX_UOPS  = 4,
  parameter int ADDR_W    = 16,
  parameter int MAX_LINES = 2,
  localparam int OP_W     = UOP_W - 1,
  localparam int CNT_W    = $clog2(MAX_UOPS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     missIn,
  input  logic                     instValid,
  input  logic [ADDR_W-1:0]        instAddr,
  input  logic [CNT_W-1:0]         instCount,
  input  logic [MAX_UOPS*OP_W-1:0] instUops,
  input  logic                     instLong,
  input  logic [OP_W-1:0]          instEntry,
  input  logic                     instBranch,
  input  logic                     predTaken,
  input  logic                     segEnd,
  output logic                     wrEn,
  output logic [ADDR_W-1:0]        wrTag,
  output logic [SLOTS-1:0]         wrValid,
  output logic [SLOTS*UOP_W-1:0]   wrSlots,
  output logic [SLOTS-1:0]         wrTaken,
  output logic                     fillDone
);

  localparam int FILL_W = $clog2(SLOTS + 1);

  tsegCtl_t          ctl;
  logic [FILL_W-1:0] fill;

  tseg_ctrl #(
    .SLOTS(SLOTS), .MAX_UOPS(MAX_UOPS), .MAX_LINES(MAX_LINES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .missIn(missIn), .instValid(instValid),
    .instCount(instCount), .instLong(instLong), .segEnd(segEnd),
    .fill(fill), .ctl(ctl), .fillDone(fillDone)
  );

  tseg_dpath #(
    .SLOTS(SLOTS), .UOP_W(UOP_W), .MAX_UOPS(MAX_UOPS), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .instAddr(instAddr),
    .instCount(instCount), .instUops(instUops), .instLong(instLong),
    .instEntry(instEntry), .instBranch(instBranch), .predTaken(predTaken),
    .fill(fill), .wrEn(wrEn), .wrTag(wrTag), .wrValid(wrValid),
    .wrSlots(wrSlots), .wrTaken(wrTaken)
  );

endmodule

// File: rtl/tseg_checker.sv
module tseg_checker #(
  parameter int SLOTS = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             instValid,
  input logic             segEnd,
  input logic             wrEn,
  input logic [SLOTS-1:0] wrValid,
  input logic [SLOTS-1:0] wrTaken,
  input logic             fillDone
);

  // R11: every write is caused by an input sampled one edge earlier
  p_write_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(instValid || segEnd));

  // R7: the slot mask is nonzero and contiguous from bit 0
  p_mask_contig_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrValid != '0 && (wrValid & (wrValid + 1'b1)) == '0));

  // R3: direction bits only sit on occupied slots
  p_taken_in_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((wrTaken & ~wrValid) == '0));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |=> !fillDone);

  // R9: completion follows an instruction or an end request
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |-> $past(instValid || segEnd));

endmodule

bind tseg_builder tseg_checker #(.SLOTS(SLOTS)) u_tseg_checker (
  .clk(clk), .rstN(rstN), .instValid(instValid), .segEnd(segEnd),
  .wrEn(wrEn), .wrValid(wrValid), .wrTaken(wrTaken), .fillDone(fillDone)
);

// File: tb/tseg_builder_bench.sv
`timescale 1ns/1ps
module tseg_builder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missIn = 1'b0, instValid = 1'b0, instLong = 1'b0;
  logic        instBranch = 1'b0, predTaken = 1'b0, segEnd = 1'b0;
  logic [15:0] instAddr = '0;
  logic [2:0]  instCount = '0;
  logic [59:0] instUops = '0;
  logic [14:0] instEntry = '0;
  logic        wrEn, fillDone;
  logic [15:0] wrTag;
  logic [5:0]  wrValid, wrTaken;
  logic [95:0] wrSlots;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tseg_builder u_tseg_builder (
    .clk(clk), .rstN(rstN), .missIn(missIn), .instValid(instValid),
    .instAddr(instAddr), .instCount(instCount), .instUops(instUops),
    .instLong(instLong), .instEntry(instEntry), .instBranch(instBranch),
    .predTaken(predTaken), .segEnd(segEnd), .wrEn(wrEn), .wrTag(wrTag),
    .wrValid(wrValid), .wrSlots(wrSlots), .wrTaken(wrTaken), .fillDone(fillDone)
  );

  typedef struct packed {
    logic        miss;
    logic        vld;
    logic [15:0] addr;
    logic [2:0]  cnt;
    logic        lng;
    logic        br;
    logic        tk;
    logic        send;
    logic        expWr;
    logic [2:0]  expCnt;
    logic [15:0] expTag;
    logic        expDone;
  } row_t;

  localparam int NROWS = 20;
  localparam row_t TBL [0:NROWS-1] = '{
    // idle: instruction ignored (R1)
    '{1'b0,1'b1,16'h0010,3'd2,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    '{1'b1,1'b0,16'h0000,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    '{1'b0,1'b1,16'h0020,3'd3,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    '{1'b0,1'b1,16'h0024,3'd2,1'b0,1'b1,1'b1,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    // overflow: write 5 slots, new line at 0x28 (R5)
    '{1'b0,1'b1,16'h0028,3'd2,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd5,16'h0020,1'b0},
    // long with count 3 takes one slot (R4)
    '{1'b0,1'b1,16'h002c,3'd3,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    // exact fill, second line ends segment (R6, R8)
    '{1'b0,1'b1,16'h0030,3'd3,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd6,16'h0028,1'b1},
    '{1'b0,1'b1,16'h0034,3'd1,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    '{1'b1,1'b0,16'h0000,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    '{1'b0,1'b1,16'h0040,3'd4,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    '{1'b0,1'b1,16'h0044,3'd2,1'b0,1'b1,1'b0,1'b0, 1'b1,3'd6,16'h0040,1'b0},
    '{1'b0,1'b1,16'h0048,3'd1,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    // end request with instruction in same cycle (R9)
    '{1'b0,1'b1,16'h004c,3'd4,1'b0,1'b0,1'b0,1'b1, 1'b1,3'd1,16'h0048,1'b1},
    '{1'b1,1'b0,16'h0000,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    // end request with empty line: no write (R9)
    '{1'b0,1'b0,16'h0000,3'd0,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0,16'h0000,1'b1},
    '{1'b1,1'b0,16'h0000,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    '{1'b0,1'b1,16'h0060,3'd4,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,16'h0000,1'b0},
    '{1'b0,1'b1,16'h0064,3'd3,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd4,16'h0060,1'b0},
    // overflow on last line: write, done, instruction dropped (R8)
    '{1'b0,1'b1,16'h0068,3'd4,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd3,16'h0064,1'b1},
    '{1'b0,1'b0,16'h0000,3'd0,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0,16'h0000,1'b0}
  };

  function automatic logic [14:0] uopOf(input logic [15:0] a, input int k);
    return {a[12:0], 2'(k)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic miss, input logic vld, input logic [15:0] addr,
                       input logic [2:0] cnt, input logic lng, input logic br,
                       input logic tk, input logic send, input logic [14:0] entry);
    missIn = miss; instValid = vld; instAddr = addr; instCount = cnt;
    instLong = lng; instBranch = br; predTaken = tk; segEnd = send;
    instEntry = entry;
    for (int k = 0; k < 4; k++) instUops[k*15 +: 15] = uopOf(addr, k);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "wrEn in reset", 64'(wrEn), 64'd0);
    chk("R10", "fillDone in reset", 64'(fillDone), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].miss, TBL[i].vld, TBL[i].addr, TBL[i].cnt, TBL[i].lng,
            TBL[i].br, TBL[i].tk, TBL[i].send, 15'h0011);
      step();
      chk("R11", $sformatf("row %0d wrEn", i), 64'(wrEn), 64'(TBL[i].expWr));
      chk("R8", $sformatf("row %0d fillDone", i), 64'(fillDone), 64'(TBL[i].expDone));
      if (TBL[i].expWr) begin
        chk("R7", $sformatf("row %0d wrValid", i), 64'(wrValid),
            64'((6'd1 << TBL[i].expCnt) - 6'd1));
        chk("R7", $sformatf("row %0d wrTag", i), 64'(wrTag), 64'(TBL[i].expTag));
      end
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step();

    // directed: branch keeps line open, tag slot, slot layout (R2 R3 R4 R6)
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); step();
    drive(0, 1, 16'h0080, 3'd2, 0, 1, 1, 0, 0); step();
    chk("R3", "no write at branch", 64'(wrEn), 64'd0);
    drive(0, 1, 16'h0084, 3'd4, 1, 0, 0, 0, 15'h0055); step();
    drive(0, 1, 16'h0088, 3'd3, 0, 0, 0, 0, 0); step();
    chk("R6", "full line written", 64'(wrEn), 64'd1);
    chk("R7", "tag of line", 64'(wrTag), 64'h80);
    chk("R2", "slot0", 64'(wrSlots[0*16 +: 16]), 64'({1'b0, uopOf(16'h0080, 0)}));
    chk("R2", "slot1", 64'(wrSlots[1*16 +: 16]), 64'({1'b0, uopOf(16'h0080, 1)}));
    chk("R4", "slot2 tag slot", 64'(wrSlots[2*16 +: 16]), 64'({1'b1, 15'h0055}));
    for (int k = 0; k < 3; k++)
      chk("R3", $sformatf("slot%0d predicted path", 3 + k),
          64'(wrSlots[(3+k)*16 +: 16]), 64'({1'b0, uopOf(16'h0088, k)}));
    chk("R3", "taken mask", 64'(wrTaken), 64'h02);
    chk("R8", "one line is below budget", 64'(fillDone), 64'd0);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0); step();
    chk("R9", "empty end no write", 64'(wrEn), 64'd0);
    chk("R9", "empty end done", 64'(fillDone), 64'd1);

    // not-taken branch mid-line then end (R3)
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); step();
    drive(0, 1, 16'h00a0, 3'd1, 0, 1, 0, 0, 0); step();
    drive(0, 1, 16'h00a4, 3'd2, 0, 1, 1, 0, 0); step();
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0); step();
    chk("R3", "partial line written", 64'(wrEn), 64'd1);
    chk("R3", "taken mask not-taken then taken", 64'(wrTaken), 64'h04);
    chk("R7", "partial mask", 64'(wrValid), 64'h07);

    // reset during build (R10), then idle input ignored (R1)
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); step();
    drive(0, 1, 16'h0090, 3'd4, 0, 0, 0, 0, 0); step();
    rstN = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0); step();
    chk("R10", "wrEn after reset", 64'(wrEn), 64'd0);
    chk("R10", "fillDone after reset", 64'(fillDone), 64'd0);
    rstN = 1'b1; step();
    drive(0, 1, 16'h00b0, 3'd4, 0, 0, 0, 0, 0); step();
    drive(0, 1, 16'h00b4, 3'd4, 0, 0, 0, 0, 0); step();
    chk("R1", "idle after reset no write", 64'(wrEn), 64'd0);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0); step();
    chk("R1", "idle end ignored", 64'(fillDone), 64'd0);
    // a fresh segment starts empty after reset (R10)
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); step();
    drive(0, 1, 16'h00c0, 3'd1, 0, 0, 0, 0, 0); step();
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0); step();
    chk("R10", "line empty after reset", 64'(wrValid), 64'h01);
    chk("R10", "tag after reset", 64'(wrTag), 64'hc0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0); step();

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule